// File: doc/BRIEF.md
# TDM Time Slot Interchanger

This block is a TDM switch for 8-bit speech samples. Each sample arrives on an input stream and belongs to the channel given by a free-running slot position. Each output slot may take its sample from any input channel of the previous frame, or it may be switched off. A single slot counter sets every speech-memory write address, the bank select, the connection-memory lookup and the output tag. The speech store has two banks, one per frame: one bank collects the current frame while the other supplies the frame before it. The banks trade roles when the counter wraps, so every connection has a delay of exactly one frame.

A host sets the connection map over a Wishbone classic slave port. Each map entry holds a source channel index and an enable bit. The host may rewrite entries while traffic flows. Both stream sides use valid/ready. The slot advances only when an input sample is accepted. A sample is accepted only when the single output register is empty or is being emptied in the same cycle, so `in_ready = !out_valid || out_ready`. An output held under back-pressure keeps every field unchanged until it is taken. The channel count `CHANNELS` is a parameter and must be a power of two.

Top module: `tsi_switch`

## Requirements
- R1: Each accepted input sample advances the slot by one. The slot wraps from CHANNELS-1 to 0. The output for a given slot carries that slot number on `out_slot`, and `out_first` is high only when `out_slot` is 0.
- R2: When the map entry for slot s is enabled and points at source c, the output for slot s in frame k+1 carries the sample accepted for channel c in frame k, with `out_en` high.
- R3: When the map entry for a slot is disabled, the output for that slot still appears with `out_valid` high, but `out_data` is 0 and `out_en` is low.
- R4: During the first frame after reset, there is no earlier frame to read. Every output of that frame has `out_data` 0 and `out_en` low.
- R5: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_en`, `out_slot` and `out_first` hold their values.
- R6: `wb_ack` rises in the cycle after a cycle in which `wb_cyc` and `wb_stb` are high and `wb_ack` is low. At all other times `wb_ack` is low.
- R7: A map write takes effect from the next slot that reads the entry. If a slot reads an entry in the same cycle that the entry is written, that slot uses the old entry.
- R8: A map entry is `wb_dat_i`/`wb_dat_o` of width log2(CHANNELS)+1. Bits [log2(CHANNELS)-1:0] hold the source channel and the top bit holds the enable. A read returns the stored entry on `wb_dat_o` while `wb_ack` is high.
- R9: Synchronous reset does the following: it clears `out_valid` and `wb_ack`, sets the slot to 0, returns the switch to its first-frame state, and clears the enable bit of every map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle if valid |
| in_data | input | 8 | Sample for the current slot |
| out_valid | output | 1 | Output slot present |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | 8 | Switched sample, 0 when disabled |
| out_en | output | 1 | Connection enable qualifier for this slot |
| out_slot | output | log2(CHANNELS) | Slot number of this output |
| out_first | output | 1 | High on slot 0 of a frame |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | log2(CHANNELS) | Map entry index |
| wb_dat_i | input | log2(CHANNELS)+1 | Entry to write |
| wb_dat_o | output | log2(CHANNELS)+1 | Entry read back |
| wb_ack | output | 1 | Wishbone acknowledge |

## Verification
The hardest case to reach from the ports is a host write to a map entry that lands in the same clock as the slot lookup of that entry, while the output register is stalled and the bank swap is near. To reach it, host reads and writes run in a thread of their own and overlap with stream traffic. That traffic has random valid and ready gaps over a small channel count, so the write edges cross slot lookups and frame wraps many times. The reference model marks outputs drawn from freshly written entries, so a wrong order between the write and the lookup shows up as a failure tagged R7.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter #(
  parameter int unsigned CHANNELS = 64,
  localparam int unsigned LOG_W = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [LOG_W-1:0] slot,
  output logic             last,
  output logic             bank,
  output logic             primed
);
  localparam logic [LOG_W-1:0] TOP_SLOT = LOG_W'(CHANNELS - 1);

  assign last = (slot == TOP_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      bank   <= 1'b0;
      primed <= 1'b0;
    end else if (adv) begin
      if (last) begin
        slot   <= '0;
        bank   <= ~bank;
        primed <= 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && last) |=> (slot == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && !last) |=> (slot == $past(slot) + 1'b1));
  assert_bank_swap_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && last) |=> (bank != $past(bank)));
  assert_bank_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !(adv && last) |=> $stable(bank));
endmodule

// File: rtl/tsi_speech_mem.sv
module tsi_speech_mem
  import tsi_pkg::*;
#(
  parameter int unsigned CHANNELS = 64,
  localparam int unsigned LOG_W = $clog2(CHANNELS),
  localparam int unsigned DEPTH = 2 * CHANNELS
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wr_bank,
  input  logic [LOG_W-1:0] wr_addr,
  input  sample_t          wr_data,
  input  logic [LOG_W-1:0] rd_addr,
  output sample_t          rd_data
);
  sample_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[{wr_bank, wr_addr}] <= wr_data;
  end

  // Reads always come from the bank that holds the previous frame.
  assign rd_data = store[{~wr_bank, rd_addr}];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int unsigned CHANNELS = 64,
  localparam int unsigned LOG_W = $clog2(CHANNELS),
  localparam int unsigned ENT_W = LOG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic [LOG_W-1:0] wb_adr,
  input  logic [ENT_W-1:0] wb_dat_i,
  output logic [ENT_W-1:0] wb_dat_o,
  output logic             wb_ack,
  input  logic [LOG_W-1:0] look_slot,
  output logic [LOG_W-1:0] look_src,
  output logic             look_en
);
  logic [LOG_W-1:0] src_tab [CHANNELS];
  logic [CHANNELS-1:0] en_tab;
  logic take;
  logic wr_hit;

  assign take   = wb_cyc && wb_stb && !wb_ack;
  assign wr_hit = take && wb_we;

  genvar gi;
  generate
    for (gi = 0; gi < CHANNELS; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          en_tab[gi] <= 1'b0;
        end else if (wr_hit && (wb_adr == LOG_W'(gi))) begin
          en_tab[gi] <= wb_dat_i[LOG_W];
        end
      end
      always_ff @(posedge clk) begin
        if (wr_hit && (wb_adr == LOG_W'(gi))) src_tab[gi] <= wb_dat_i[LOG_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack <= take;
      if (take && !wb_we) wb_dat_o <= {en_tab[wb_adr], src_tab[wb_adr]};
    end
  end

  assign look_src = src_tab[look_slot];
  assign look_en  = en_tab[look_slot];

  assert_ack_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);
  assert_ack_cause_R6: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb));
endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
  import tsi_pkg::*;
#(
  parameter int unsigned CHANNELS = 64,
  localparam int unsigned LOG_W = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  sample_t          nx_data,
  input  logic             nx_en,
  input  logic [LOG_W-1:0] nx_slot,
  input  logic             out_ready,
  output logic             can_load,
  output logic             out_valid,
  output sample_t          out_data,
  output logic             out_en,
  output logic [LOG_W-1:0] out_slot,
  output logic             out_first
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_en    <= 1'b0;
      out_slot  <= '0;
      out_first <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= nx_data;
      out_en    <= nx_en;
      out_slot  <= nx_slot;
      out_first <= (nx_slot == '0);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_en)
                                   && $stable(out_slot) && $stable(out_first)));
  assert_first_slot_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_first == (out_slot == '0)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned CHANNELS = 64,
  localparam int unsigned LOG_W = $clog2(CHANNELS),
  localparam int unsigned ENT_W = LOG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_en,
  output logic [LOG_W-1:0] out_slot,
  output logic             out_first,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic [LOG_W-1:0] wb_adr,
  input  logic [ENT_W-1:0] wb_dat_i,
  output logic [ENT_W-1:0] wb_dat_o,
  output logic             wb_ack
);
  logic             adv;
  logic [LOG_W-1:0] slot;
  logic             last;
  logic             bank;
  logic             primed;
  logic [LOG_W-1:0] src;
  logic             map_en;
  sample_t          prev_sample;
  logic             sel_en;
  sample_t          sel_data;

  assign adv      = in_valid && in_ready;
  assign sel_en   = primed && map_en;
  assign sel_data = sel_en ? prev_sample : '0;

  tsi_slot_counter #(.CHANNELS(CHANNELS)) u_slot (
    .clk(clk), .rst(rst), .adv(adv), .slot(slot), .last(last),
    .bank(bank), .primed(primed)
  );

  tsi_speech_mem #(.CHANNELS(CHANNELS)) u_speech (
    .clk(clk), .we(adv), .wr_bank(bank), .wr_addr(slot), .wr_data(in_data),
    .rd_addr(src), .rd_data(prev_sample)
  );

  tsi_conn_mem #(.CHANNELS(CHANNELS)) u_map (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
    .look_slot(slot), .look_src(src), .look_en(map_en)
  );

  tsi_out_stage #(.CHANNELS(CHANNELS)) u_out (
    .clk(clk), .rst(rst), .load(adv), .nx_data(sel_data), .nx_en(sel_en),
    .nx_slot(slot), .out_ready(out_ready), .can_load(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_en(out_en),
    .out_slot(out_slot), .out_first(out_first)
  );

  assert_first_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !primed) |=> (out_valid && !out_en && out_data == '0));
  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !map_en) |=> (out_valid && !out_en && out_data == '0));
  assert_out_slot_R1: assert property (@(posedge clk) disable iff (rst)
    adv |=> (out_slot == $past(slot)));
endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;
  localparam int N = 8;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [L-1:0] wb_adr = '0;
  logic [L:0] wb_dat_i = '0;
  logic in_ready, out_valid, out_en, out_first, wb_ack;
  logic [7:0] out_data;
  logic [L-1:0] out_slot;
  logic [L:0] wb_dat_o;

  always #2.5 clk = ~clk;

  tsi_switch #(.CHANNELS(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_en(out_en),
    .out_slot(out_slot), .out_first(out_first), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit checking = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cur [N], m_prev [N], m_src [N];
  bit m_en [N], m_recent [N], m_written [N];
  int m_slot, m_data, m_oslot, m_rdat;
  bit m_ov, m_oen, m_first, m_primed, m_ack, m_ackrd;
  string m_tag, m_rdtag;

  always @(posedge clk) begin
    if (rst) begin
      m_ov = 0; m_ack = 0; m_ackrd = 0; m_slot = 0; m_primed = 0;
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_recent[i] = 0; m_written[i] = 0;
      end
    end else begin
      if (in_valid && (!m_ov || out_ready)) begin
        int s;
        s = m_slot;
        m_oen = m_primed && m_en[s];
        m_data = m_oen ? m_prev[m_src[s]] : 0;
        m_oslot = s;
        m_first = (s == 0);
        m_ov = 1;
        if (!m_primed) m_tag = "R4";
        else if (!m_en[s]) m_tag = "R3";
        else if (m_recent[s]) m_tag = "R7";
        else m_tag = "R2";
        m_recent[s] = 0;
        m_cur[s] = int'(in_data);
        if (s == N - 1) begin
          for (int i = 0; i < N; i++) m_prev[i] = m_cur[i];
          m_primed = 1;
          m_slot = 0;
        end else begin
          m_slot = s + 1;
        end
      end else if (out_ready) begin
        m_ov = 0;
      end
      if (wb_cyc && wb_stb && !m_ack) begin
        m_ack = 1;
        if (wb_we) begin
          m_src[wb_adr] = int'(wb_dat_i[L-1:0]);
          m_en[wb_adr] = wb_dat_i[L];
          m_recent[wb_adr] = 1;
          m_written[wb_adr] = 1;
          m_ackrd = 0;
        end else begin
          m_rdat = m_en[wb_adr] ? (m_src[wb_adr] + N) : m_src[wb_adr];
          m_rdtag = m_written[wb_adr] ? "R8" : "R9";
          m_ackrd = 1;
        end
      end else begin
        m_ack = 0;
      end
    end
  end

  // Compare away from the active edge, on every clock
  always @(negedge clk) begin
    #1;
    if (checking) begin
      chk(in_ready == (!m_ov || out_ready), "R5 in_ready", int'(in_ready), int'(!m_ov || out_ready));
      chk(out_valid == m_ov, "R5 out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
        chk(int'(out_slot) == m_oslot, "R1 out_slot", int'(out_slot), m_oslot);
        chk(out_first == m_first, "R1 out_first", int'(out_first), int'(m_first));
        chk(out_en == m_oen, {m_tag, " out_en"}, int'(out_en), int'(m_oen));
        chk(int'(out_data) == m_data, {m_tag, " out_data"}, int'(out_data), m_data);
      end
      chk(wb_ack == m_ack, "R6 wb_ack", int'(wb_ack), int'(m_ack));
      if (m_ack && m_ackrd)
        chk(int'(wb_dat_o) == m_rdat, {m_rdtag, " wb_dat_o"}, int'(wb_dat_o), m_rdat);
    end
  end

  task automatic wb_op(input bit we, input int adr, input int dat);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = L'(adr); wb_dat_i = (L+1)'(dat);
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic stream(input int cycles, input int vgap, input int rgap);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid  = (vgap == 0) || ($urandom % vgap != 0);
      out_ready = (rgap == 0) || ($urandom % rgap != 0);
      in_data   = 8'($urandom);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    // R9: reset state at the ports
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(wb_ack == 1'b0, "R9 wb_ack after reset", int'(wb_ack), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    checking = 1;
    // R9: every entry reads back disabled before any write
    for (int i = 0; i < N; i++) wb_op(0, i, 0);
    fork
      begin
        stream(400, 0, 0);
        stream(1200, 3, 3);
        stream(600, 0, 2);
        stream(400, 0, 0);
      end
      begin
        for (int i = 0; i < N; i++) wb_op(1, i, N + (N - 1 - i));
        for (int k = 0; k < 700; k++) begin
          if ($urandom % 2 == 0) wb_op(1, $urandom % N, $urandom % (2 * N));
          else wb_op(0, $urandom % N, 0);
        end
      end
    join
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    checking = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule